// File: doc/BRIEF.md
# USB Host Controller Command and Status Register Block

This block holds the run/stop, reset and status state of a USB host controller that sits behind a 64 KiB memory-mapped register window. It decodes single-cycle writes to four registers: command, status, command ring control and interrupter management. It keeps the halted, controller-not-ready and host-system-error status bits. It latches the command ring dequeue pointer and consumer cycle state. It drives a combined interrupter-enable output to the interrupt logic.

Stopping and resetting are split-phase operations. A write to the command register issues a one-cycle request to the slot and ring logic. The matching status change waits for that logic to answer on a done input. A fatal-error input puts the block into a sticky failed state. From then on, every write is discarded and every read still returns data.

Top module: `hc_cmdstat_regs`

## Requirements
- R1: A write to the command register (offset 0x00) with bit 1 (reset) set stores the written value with bit 1 cleared, sets controller-not-ready and pulses `reset_req` for one cycle. The halted bit is not changed by such a write.
- R2: Controller-not-ready (status bit 11) stays set until `reset_done` arrives while a reset is outstanding. A `stop_done` pulse does not clear it.
- R3: A command write with bit 1 clear and bit 0 (run/stop) set clears halted (status bit 0). The same write with bit 0 clear pulses `stop_req` for one cycle and clears the ring-running bit (command ring control bit 3).
- R4: After a stop request, halted stays clear until `stop_done` arrives. It becomes 1 in the cycle after `stop_done`.
- R5: `intr_en` equals command bit 2 AND interrupter-management bit 1 (offset 0x20). It is updated whenever either register is written.
- R6: A write to the command ring control register (offset 0x18) loads the pointer from data bits 63:6 and the cycle state from data bit 0, but only while ring-running is clear. While the ring is running, the old values are kept. `ring_go` sets ring-running while command bit 0 is 1.
- R7: On `fatal_err`, the command register becomes 0, the status register becomes exactly 0x4 (host-system-error, bit 2), `intr_en` becomes 0 and `failed` becomes 1.
- R8: Once failed, the block discards all register writes and ignores all handshakes, while reads keep returning the stored values. The failed state is left only by power-on reset.
- R9: A write whose address is outside [BASE, BASE+64 KiB) has no effect. A read outside that window returns 0. The status register ignores writes.
- R10: After power-on reset, status reads 0x1 (halted only), the command register reads 0, `intr_en` is 0 and `failed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 64 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 64 | Read data, combinational from `rd_addr` |
| fatal_err | input | 1 | Fatal error event, enters the failed state |
| ring_go | input | 1 | Command ring doorbell, sets ring-running |
| stop_done | input | 1 | All slots have stopped |
| reset_done | input | 1 | All slots have stopped and been reset |
| stop_req | output | 1 | One-cycle stop request to slot logic |
| reset_req | output | 1 | One-cycle reset request to slot logic |
| intr_en | output | 1 | Combined interrupter enable |
| crc_ptr | output | 58 | Command ring dequeue pointer, address bits 63:6 |
| crc_cycle | output | 1 | Consumer cycle state |
| failed | output | 1 | Sticky failed flag |

## Verification
The assertions check several properties on every cycle:
- The failed flag is sticky, and while it is set the command and status registers stay at their forced values.
- The halted bit rises only right after a stop handshake.
- Controller-not-ready falls only right after a reset handshake.
- A ring-control write during a running ring leaves the pointer and cycle state unchanged.
- The interrupter output never asserts without both enable bits set.

The directed scenarios cover what a per-cycle property cannot: the self-clearing reset bit in the stored value, the ordering of request pulses and delayed status updates, the window bounds, and the fact that reads still work after a failure.

// File: rtl/hc_regs_pkg.sv
package hc_regs_pkg;
    // Register offsets inside the window
    localparam int OFS_CMD  = 'h00;
    localparam int OFS_STS  = 'h04;
    localparam int OFS_CRC  = 'h18;
    localparam int OFS_IMAN = 'h20;

    // Command bits
    localparam int CMD_RUN = 0;
    localparam int CMD_RST = 1;
    localparam int CMD_IE  = 2;
    // Status bits
    localparam int STS_HLT = 0;
    localparam int STS_HSE = 2;
    localparam int STS_CNR = 11;
    // Ring control bits
    localparam int CRC_RCS = 0;
    localparam int CRC_CRR = 3;
    localparam int CRC_PTR_LSB = 6;
    localparam int CRC_PTR_W = 64 - CRC_PTR_LSB;
    // Interrupter management bit
    localparam int IMAN_IE = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_STS,
        SEL_CRC,
        SEL_IMAN
    } reg_sel_e;
endpackage

// File: rtl/hc_addr_dec.sv
module hc_addr_dec
    import hc_regs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 'h0001_0000,
    parameter int WIN_BYTES = 65536
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output reg_sel_e          sel
);
    localparam int OFS_W = $clog2(WIN_BYTES);

    logic [ADDR_W-1:0] diff;
    logic [OFS_W-1:0]  ofs;

    always_comb begin
        diff   = addr - BASE;
        ofs    = diff[OFS_W-1:0];
        in_win = (addr >= BASE) && (diff < ADDR_W'(WIN_BYTES));
        sel    = SEL_NONE;
        if (in_win) begin
            if (ofs == OFS_W'(OFS_CMD))       sel = SEL_CMD;
            else if (ofs == OFS_W'(OFS_STS))  sel = SEL_STS;
            else if (ofs == OFS_W'(OFS_CRC))  sel = SEL_CRC;
            else if (ofs == OFS_W'(OFS_IMAN)) sel = SEL_IMAN;
        end
    end
endmodule

// File: rtl/hc_cmd_unit.sv
module hc_cmd_unit
    import hc_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cmd,
    input  logic        wr_iman,
    input  logic [31:0] wdata,
    input  logic        fatal_err,
    input  logic        stop_done,
    input  logic        reset_done,
    output logic [31:0] cmd,
    output logic [31:0] sts,
    output logic        iman_ie,
    output logic        intr_en,
    output logic        failed,
    output logic        stop_req,
    output logic        reset_req,
    output logic        ring_clr
);
    typedef struct packed {
        logic [31:0] cmd;
        logic        hlt;
        logic        cnr;
        logic        hse;
        logic        failed;
        logic        iman_ie;
        logic        intr_en;
        logic        stop_pend;
        logic        rst_pend;
        logic        stop_req;
        logic        reset_req;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.stop_req  = 1'b0;
        st_d.reset_req = 1'b0;
        ring_clr       = 1'b0;
        if (st_q.failed) begin
            // frozen: nothing changes until power-on reset
        end else if (fatal_err) begin
            st_d.cmd       = '0;
            st_d.hlt       = 1'b0;
            st_d.cnr       = 1'b0;
            st_d.hse       = 1'b1;
            st_d.failed    = 1'b1;
            st_d.intr_en   = 1'b0;
            st_d.stop_pend = 1'b0;
            st_d.rst_pend  = 1'b0;
        end else begin
            if (stop_done && st_q.stop_pend) begin
                st_d.hlt       = 1'b1;
                st_d.stop_pend = 1'b0;
            end
            if (reset_done && st_q.rst_pend) begin
                st_d.cnr      = 1'b0;
                st_d.rst_pend = 1'b0;
            end
            if (wr_cmd) begin
                if (wdata[CMD_RST]) begin
                    st_d.cmd          = wdata;
                    st_d.cmd[CMD_RST] = 1'b0;
                    st_d.cnr          = 1'b1;
                    st_d.rst_pend     = 1'b1;
                    st_d.reset_req    = 1'b1;
                end else begin
                    st_d.cmd = wdata;
                    if (wdata[CMD_RUN]) begin
                        st_d.hlt = 1'b0;
                    end else begin
                        st_d.stop_pend = 1'b1;
                        st_d.stop_req  = 1'b1;
                        ring_clr       = 1'b1;
                    end
                end
            end
            if (wr_iman) st_d.iman_ie = wdata[IMAN_IE];
            if (wr_cmd || wr_iman) st_d.intr_en = st_d.cmd[CMD_IE] & st_d.iman_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.hlt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sts          = '0;
        sts[STS_HLT] = st_q.hlt;
        sts[STS_HSE] = st_q.hse;
        sts[STS_CNR] = st_q.cnr;
    end

    assign cmd       = st_q.cmd;
    assign iman_ie   = st_q.iman_ie;
    assign intr_en   = st_q.intr_en;
    assign failed    = st_q.failed;
    assign stop_req  = st_q.stop_req;
    assign reset_req = st_q.reset_req;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.failed |=> st_q.failed); // R8
    AST_FAIL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.failed |-> (st_q.cmd == '0) && (sts == 32'h4)); // R7
    AST_HALT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hlt) |-> $past(stop_done)); // R4
    AST_CNR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.cnr) && !st_q.failed) |-> $past(reset_done)); // R2
endmodule

// File: rtl/hc_ring_ctl.sv
module hc_ring_ctl
    import hc_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_crc,
    input  logic [63:0]          wdata,
    input  logic                 ring_set,
    input  logic                 ring_clr,
    output logic [CRC_PTR_W-1:0] ptr,
    output logic                 rcs,
    output logic                 crr
);
    typedef struct packed {
        logic [CRC_PTR_W-1:0] ptr;
        logic                 rcs;
        logic                 crr;
    } ring_state_t;

    ring_state_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (wr_crc && !rs_q.crr) begin
            rs_d.ptr = wdata[63:CRC_PTR_LSB];
            rs_d.rcs = wdata[CRC_RCS];
        end
        if (ring_clr)      rs_d.crr = 1'b0;
        else if (ring_set) rs_d.crr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ptr = rs_q.ptr;
    assign rcs = rs_q.rcs;
    assign crr = rs_q.crr;

    AST_CRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_crc && rs_q.crr) |=> ($stable(rs_q.ptr) && $stable(rs_q.rcs))); // R6
endmodule

// File: rtl/hc_cmdstat_regs.sv
module hc_cmdstat_regs
    import hc_regs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 'h0001_0000,
    parameter int WIN_BYTES = 65536
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [63:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [63:0]          rd_data,
    input  logic                 fatal_err,
    input  logic                 ring_go,
    input  logic                 stop_done,
    input  logic                 reset_done,
    output logic                 stop_req,
    output logic                 reset_req,
    output logic                 intr_en,
    output logic [CRC_PTR_W-1:0] crc_ptr,
    output logic                 crc_cycle,
    output logic                 failed
);
    logic      w_in, r_in;
    reg_sel_e  w_sel, r_sel;
    logic      wr_ok;
    logic [31:0] cmd_v, sts_v;
    logic      iman_ie, ring_clr, crr;

    hc_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_BYTES(WIN_BYTES)) u_wdec (
        .addr(wr_addr), .in_win(w_in), .sel(w_sel));
    hc_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_BYTES(WIN_BYTES)) u_rdec (
        .addr(rd_addr), .in_win(r_in), .sel(r_sel));

    assign wr_ok = wr_en && w_in && !failed && !fatal_err;

    hc_cmd_unit u_cmd (
        .clk(clk), .rst_n(rst_n),
        .wr_cmd(wr_ok && (w_sel == SEL_CMD)),
        .wr_iman(wr_ok && (w_sel == SEL_IMAN)),
        .wdata(wr_data[31:0]),
        .fatal_err(fatal_err), .stop_done(stop_done), .reset_done(reset_done),
        .cmd(cmd_v), .sts(sts_v), .iman_ie(iman_ie), .intr_en(intr_en),
        .failed(failed), .stop_req(stop_req), .reset_req(reset_req),
        .ring_clr(ring_clr));

    hc_ring_ctl u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_crc(wr_ok && (w_sel == SEL_CRC)),
        .wdata(wr_data),
        .ring_set(ring_go && cmd_v[CMD_RUN] && !failed && !fatal_err),
        .ring_clr(ring_clr),
        .ptr(crc_ptr), .rcs(crc_cycle), .crr(crr));

    always_comb begin
        rd_data = '0;
        unique case (r_sel)
            SEL_CMD:  rd_data = {32'h0, cmd_v};
            SEL_STS:  rd_data = {32'h0, sts_v};
            SEL_CRC:  rd_data = {crc_ptr, 2'b00, crr, 2'b00, crc_cycle};
            SEL_IMAN: rd_data = {62'h0, iman_ie, 1'b0};
            default:  rd_data = '0;
        endcase
        if (!r_in) rd_data = '0;
    end

    AST_IE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        intr_en |-> (cmd_v[CMD_IE] && iman_ie)); // R5
endmodule

// File: tb/hc_cmdstat_regs_tb.sv
module hc_cmdstat_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] rd_addr = '0;
    logic [63:0] rd_data;
    logic        fatal_err = 1'b0, ring_go = 1'b0, stop_done = 1'b0, reset_done = 1'b0;
    logic        stop_req, reset_req, intr_en, crc_cycle, failed;
    logic [57:0] crc_ptr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_cmdstat_regs #(.ADDR_W(32), .BASE(BASE), .WIN_BYTES(65536)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fatal_err(fatal_err), .ring_go(ring_go),
        .stop_done(stop_done), .reset_done(reset_done), .stop_req(stop_req),
        .reset_req(reset_req), .intr_en(intr_en), .crc_ptr(crc_ptr),
        .crc_cycle(crc_cycle), .failed(failed));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] ofs, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = BASE + ofs; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_abs(logic [31:0] a, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [31:0] a, output logic [63:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_done = 1'b1; @(negedge clk); stop_done = 1'b0;
    endtask
    task automatic pulse_reset();
        @(negedge clk); reset_done = 1'b1; @(negedge clk); reset_done = 1'b0;
    endtask
    task automatic pulse_go();
        @(negedge clk); ring_go = 1'b1; @(negedge clk); ring_go = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [63:0] v;
        rd(BASE + 'h04, v); chk("R10 status", v, 64'h1);
        rd(BASE + 'h00, v); chk("R10 command", v, 64'h0);
        chk("R10 intr_en", intr_en, 0);
        chk("R10 failed", failed, 0);
    endtask

    task automatic t_run_stop();
        logic [63:0] v;
        wr('h00, 64'h1);
        rd(BASE + 'h04, v); chk("R3 halted cleared", v, 64'h0);
        chk("R3 no stop_req on run", stop_req, 0);
        wr('h00, 64'h0);
        chk("R3 stop_req pulse", stop_req, 1);
        rd(BASE + 'h04, v); chk("R4 halted waits", v, 64'h0);
        @(negedge clk);
        chk("R3 stop_req one cycle", stop_req, 0);
        pulse_stop();
        rd(BASE + 'h04, v); chk("R4 halted after done", v, 64'h1);
    endtask

    task automatic t_intr();
        wr('h00, 64'h5);
        chk("R5 iman off", intr_en, 0);
        wr('h20, 64'h2);
        chk("R5 both set", intr_en, 1);
        wr('h00, 64'h1);
        chk("R5 cmd ie off", intr_en, 0);
        wr('h00, 64'h5);
        chk("R5 cmd ie on", intr_en, 1);
    endtask

    task automatic t_ring();
        logic [63:0] v;
        wr('h18, 64'h0000_1234_5678_9AC1);
        chk("R6 ptr load", crc_ptr, 58'(64'h0000_1234_5678_9AC1 >> 6));
        chk("R6 cycle load", crc_cycle, 1);
        pulse_go();
        rd(BASE + 'h18, v); chk("R6 running set", v[3], 1);
        wr('h18, 64'hFFFF_0000_0000_0040);
        chk("R6 ptr held", crc_ptr, 58'(64'h0000_1234_5678_9AC1 >> 6));
        chk("R6 cycle held", crc_cycle, 1);
        wr('h00, 64'h4);
        rd(BASE + 'h18, v); chk("R3 running cleared", v[3], 0);
        chk("R5 ie kept", intr_en, 1);
        pulse_stop();
        wr('h18, 64'h0000_0000_0000_0080);
        chk("R6 ptr after stop", crc_ptr, 58'h2);
        chk("R6 cycle after stop", crc_cycle, 0);
    endtask

    task automatic t_ctrl_reset();
        logic [63:0] v;
        wr('h00, 64'h3);
        chk("R1 reset_req", reset_req, 1);
        rd(BASE + 'h00, v); chk("R1 reset bit self-clears", v, 64'h1);
        rd(BASE + 'h04, v); chk("R2 not-ready set", v, 64'h801);
        pulse_stop();
        repeat (3) @(negedge clk);
        rd(BASE + 'h04, v); chk("R2 still not ready", v, 64'h801);
        pulse_reset();
        rd(BASE + 'h04, v); chk("R2 not-ready cleared", v, 64'h1);
    endtask

    task automatic t_window();
        logic [63:0] v;
        wr_abs(BASE + 32'h0001_0000, 64'h0);
        wr_abs(BASE - 32'h4, 64'h0);
        rd(BASE + 'h00, v); chk("R9 outside write ignored", v, 64'h1);
        chk("R9 no stop_req", stop_req, 0);
        rd(BASE + 32'h0001_0000, v); chk("R9 outside read zero", v, 64'h0);
        wr('h04, 64'hFFFF_FFFF);
        rd(BASE + 'h04, v); chk("R9 status read-only", v, 64'h1);
    endtask

    task automatic t_fatal();
        logic [63:0] v;
        @(negedge clk); fatal_err = 1'b1; @(negedge clk); fatal_err = 1'b0;
        rd(BASE + 'h00, v); chk("R7 command zero", v, 64'h0);
        rd(BASE + 'h04, v); chk("R7 status hse", v, 64'h4);
        chk("R7 intr_en off", intr_en, 0);
        chk("R7 failed", failed, 1);
        wr('h00, 64'h7);
        rd(BASE + 'h00, v); chk("R8 command write dropped", v, 64'h0);
        chk("R8 no reset_req", reset_req, 0);
        wr('h18, 64'h0000_0000_0000_1001);
        chk("R8 ring write dropped", crc_ptr, 58'h2);
        wr('h20, 64'h0);
        rd(BASE + 'h20, v); chk("R8 iman read kept", v, 64'h2);
        pulse_reset(); pulse_stop();
        rd(BASE + 'h04, v); chk("R8 handshakes ignored", v, 64'h4);
        chk("R8 failed sticky", failed, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_run_stop();
        t_intr();
        t_ring();
        t_ctrl_reset();
        t_window();
        t_fatal();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule